// File: doc/BRIEF.md
# Register-Mapped Hardware Mutex Arbiter

This block is one hardware lock that up to 32 software agents share. Each agent owns one bit position in two registers on a plain memory-mapped bus. An agent asks for the lock by writing a one to its bit of the request register. It polls the grant register until its own bit shows there. When it is done it writes a one to that grant bit to hand the lock back. An agent whose request is still waiting can withdraw it by writing a one to its own grant bit while it is not the owner.

The block keeps the set of waiting requests and decides who gets the lock next. The lowest-numbered waiting agent always wins. The owner is shown as a one-hot value. After every release the lock stays visibly free for one cycle. Writes are applied on the clock edge that samples them. Reads return the addressed register combinationally.

Top module: `hw_mutex_arb`

## Requirements
- R1: Reset (asynchronous, active low) clears both registers, so the lock is free and no request is pending.
- R2: Writing a 1 to bit i of the request register (word address 0) makes agent i pending from the next clock edge on. The bit reads back as 1 until that agent is granted or cancels.
- R3: Writing 0 to a request bit has no effect on that bit.
- R4: The grant register (word address 1) never has more than one bit set. That bit is the owner, and the register reads all zeros when the lock is free.
- R5: While the lock is free and requests are pending, the lowest-numbered pending agent is granted on the next clock edge. Its request bit clears on that same edge.
- R6: Writing a 1 to the set grant bit releases the lock on the next edge. The grant register then reads zero for at least one cycle, and the owner never changes straight to another owner.
- R7: Writing a 1 to a grant bit that is not set clears that agent's pending request and leaves the owner unchanged. If that agent has no request pending, nothing changes.
- R8: One grant-register write that carries a release and cancellations together applies all of them on the same edge.
- R9: Word addresses other than 0 and 1 read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (2) | Word address: 0 request, 1 grant |
| bus_wdata | input | N_AGENTS (32) | Write data, one bit per agent |
| bus_rdata | output | N_AGENTS (32) | Combinational read data of the addressed word |

## Verification
The arbitration path is driven first with a single lone request. It is then driven with several requests written while the lock is held, so that the lowest-index choice is separated from arrival order. A wide burst of high-numbered requests follows, which shows whether the grant stays one-hot when many bits compete. The grant-register write is tried with the owner's bit alone, with a waiting agent's bit alone, with an idle agent's bit, and with a mix of owner and waiting bits. These patterns tell release, cancel, no-op and combined handling apart. Writes of all zeros and writes to unmapped addresses confirm that neither kind of write disturbs the state.

// File: rtl/hw_mutex_pkg.sv
package hw_mutex_pkg;
  // word index of each register on the bus
  localparam int unsigned WORD_REQUEST = 0;
  localparam int unsigned WORD_GRANT   = 1;
endpackage

// File: rtl/mtx_bus_decode.sv
module mtx_bus_decode
  import hw_mutex_pkg::*;
#(
  parameter int unsigned N_AGENTS = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [N_AGENTS-1:0] bus_wdata,
  input  logic [N_AGENTS-1:0] req_q,
  input  logic [N_AGENTS-1:0] gnt_q,
  output logic [N_AGENTS-1:0] set_vec,
  output logic [N_AGENTS-1:0] gnt_wr_vec,
  output logic [N_AGENTS-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(WORD_REQUEST);
  localparam logic [ADDR_W-1:0] A_GNT = ADDR_W'(WORD_GRANT);

  logic hit_req, hit_gnt;

  always_comb begin
    hit_req    = (bus_addr == A_REQ);
    hit_gnt    = (bus_addr == A_GNT);
    set_vec    = (bus_wr && hit_req) ? bus_wdata : '0;
    gnt_wr_vec = (bus_wr && hit_gnt) ? bus_wdata : '0;
    if (hit_req)      bus_rdata = req_q;
    else if (hit_gnt) bus_rdata = gnt_q;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/mtx_lowest_pick.sv
module mtx_lowest_pick #(
  parameter int unsigned N_AGENTS = 32
) (
  input  logic [N_AGENTS-1:0] cand,
  output logic [N_AGENTS-1:0] pick
);
  // seen[i] is set when any candidate below index i exists
  logic [N_AGENTS:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_chain
    assign seen[i+1] = seen[i] | cand[i];
    assign pick[i]   = cand[i] & ~seen[i];
  end
endmodule

// File: rtl/mtx_lock_core.sv
module mtx_lock_core #(
  parameter int unsigned N_AGENTS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] set_vec,
  input  logic [N_AGENTS-1:0] gnt_wr_vec,
  output logic [N_AGENTS-1:0] req_q,
  output logic [N_AGENTS-1:0] gnt_q
);
  logic [N_AGENTS-1:0] req_d, gnt_d;
  logic [N_AGENTS-1:0] withdraw, cand, pick, award;
  logic                free, release_hit, upd_en;

  mtx_lowest_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .cand (cand),
    .pick (pick)
  );

  always_comb begin
    free        = ~|gnt_q;
    release_hit = |(gnt_wr_vec & gnt_q);
    withdraw    = gnt_wr_vec & ~gnt_q;
    cand        = req_q & ~withdraw;
    award       = free ? pick : '0;
    req_d       = (req_q | set_vec) & ~withdraw & ~award;
    if (release_hit) gnt_d = '0;
    else if (free)   gnt_d = award;
    else             gnt_d = gnt_q;
    upd_en      = (|set_vec) | (|gnt_wr_vec) | (free & (|req_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      gnt_q <= '0;
    end else if (upd_en) begin
      req_q <= req_d;
      gnt_q <= gnt_d;
    end
  end
endmodule

// File: rtl/hw_mutex_arb.sv
module hw_mutex_arb #(
  parameter int unsigned N_AGENTS = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [N_AGENTS-1:0] bus_wdata,
  output logic [N_AGENTS-1:0] bus_rdata
);
  logic [N_AGENTS-1:0] set_vec, gnt_wr_vec, req_q, gnt_q;

  mtx_bus_decode #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .req_q      (req_q),
    .gnt_q      (gnt_q),
    .set_vec    (set_vec),
    .gnt_wr_vec (gnt_wr_vec),
    .bus_rdata  (bus_rdata)
  );

  mtx_lock_core #(.N_AGENTS(N_AGENTS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .gnt_wr_vec (gnt_wr_vec),
    .req_q      (req_q),
    .gnt_q      (gnt_q)
  );
endmodule

// File: rtl/hw_mutex_arb_chk.sv
module hw_mutex_arb_chk
  import hw_mutex_pkg::*;
#(
  parameter int unsigned N_AGENTS = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [N_AGENTS-1:0] bus_wdata,
  input logic [N_AGENTS-1:0] req_q,
  input logic [N_AGENTS-1:0] gnt_q
);
  logic                gwrite;
  logic [N_AGENTS-1:0] gbits;

  always_comb begin
    gwrite = bus_wr && (bus_addr == ADDR_W'(WORD_GRANT));
    gbits  = gwrite ? bus_wdata : '0;
  end

  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_clear_R1: assert (req_q == '0 && gnt_q == '0);
  end

  assert_pending_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(req_q) & ~req_q & ~gnt_q & ~$past(gbits)) == '0));

  assert_onehot_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && req_q != '0 && !gwrite)
      |=> (gnt_q == ($past(req_q) & (~$past(req_q) + 1'b1))));

  assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gwrite && ((bus_wdata & gnt_q) != '0)) |=> (gnt_q == '0));

  assert_no_direct_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |=> (gnt_q == '0 || $stable(gnt_q)));

  assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gwrite |=> ((req_q & $past(bus_wdata & ~gnt_q)) == '0));
endmodule

bind hw_mutex_arb hw_mutex_arb_chk #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .req_q     (req_q),
  .gnt_q     (gnt_q)
);

// File: tb/tb_hw_mutex_arb.sv
module tb_hw_mutex_arb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N  = 32;
  localparam int  AW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  hw_mutex_arb #(.N_AGENTS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one write across one rising edge, return at the following falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_regs(input string req, input logic [N-1:0] r, input logic [N-1:0] g);
    logic [N-1:0] v;
    rd(2'd0, v); check({req, " request"}, v, r);
    rd(2'd1, v); check({req, " grant"}, v, g);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    expect_regs("R1 reset", '0, '0);
    rst_n = 1'b1;
    idle(1);
    expect_regs("R1 after release", '0, '0);
  endtask

  task automatic t_single;
    wr(2'd0, 32'h0000_0020);
    expect_regs("R2 lone request", 32'h20, '0);
    idle(1);
    expect_regs("R5 lone grant", '0, 32'h20);
  endtask

  task automatic t_hold;
    wr(2'd0, 32'h0000_0208);
    idle(3);
    expect_regs("R2 held while busy", 32'h208, 32'h20);
    wr(2'd0, 32'h0);
    expect_regs("R3 zero write", 32'h208, 32'h20);
  endtask

  task automatic t_release;
    wr(2'd1, 32'h0000_0020);
    expect_regs("R6 free gap", 32'h208, '0);
    idle(1);
    expect_regs("R5 lowest wins", 32'h200, 32'h8);
  endtask

  task automatic t_cancel;
    wr(2'd1, 32'h0000_0200);
    expect_regs("R7 cancel pending", '0, 32'h8);
    wr(2'd1, 32'h0000_4000);
    expect_regs("R7 cancel idle agent", '0, 32'h8);
  endtask

  task automatic t_combined;
    wr(2'd0, 32'h0000_0082);
    wr(2'd1, 32'h0000_000A);
    expect_regs("R8 release plus cancel", 32'h80, '0);
    idle(1);
    expect_regs("R8 next owner", '0, 32'h80);
  endtask

  task automatic t_unmapped;
    logic [N-1:0] v;
    wr(2'd2, '1);
    wr(2'd3, '1);
    rd(2'd2, v); check("R9 read word 2", v, '0);
    rd(2'd3, v); check("R9 read word 3", v, '0);
    expect_regs("R9 state untouched", '0, 32'h80);
  endtask

  task automatic t_burst;
    logic [N-1:0] v;
    wr(2'd1, 32'h0000_0080);
    wr(2'd0, 32'hF0F0_0000);
    expect_regs("R6 burst gap", 32'hF0F0_0000, '0);
    idle(1);
    rd(2'd1, v);
    check("R4 single owner", 32'($countones(v)), 32'd1);
    expect_regs("R5 burst lowest", 32'hF0E0_0000, 32'h0010_0000);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_regs("R1 mid-run reset", '0, '0);
    idle(2);
    rst_n = 1'b1;
    idle(2);
    expect_regs("R1 stays clear", '0, '0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_hold();
    t_release();
    t_cancel();
    t_combined();
    t_unmapped();
    t_burst();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule